// File: doc/BRIEF.md
# Instruction Bundle Unpacker and Group Dispatcher

This block sits between an instruction fetch buffer and the issue stage. Each cycle it may receive up to two 128-bit bundles. Each bundle carries a 5-bit template and three 41-bit instruction slots. The template alone says which kind of execution unit each slot needs and where the parallel issue groups end. The block does not look inside the instructions.

Legal bundles are split into slot entries. Each entry is tagged with its unit type and a stop flag, and the entries go into a small slot buffer in program order. Each cycle the block emits one issue group from the head of that buffer on up to six output lanes. A group may start in one bundle and finish in the next. A bundle whose template is one of the reserved codes is dropped whole, and a one-cycle illegal flag is raised. A synchronous flush empties the buffer and the output lanes.

Top module: `bundle_dispatch`

## Requirements
- R1: The template is bundle bits 4:0, slot 0 is bits 45:5, slot 1 is bits 86:46 and slot 2 is bits 127:87. Each emitted lane carries the 41-bit field of its slot unchanged.
- R2: Unit codes are memory=0, integer=1, floating=2, branch=3 and long=4. The template bits 4:1 choose the units of slots 0/1/2 as follows:
  - 0 and 1: M,I,I
  - 2: M,L,L
  - 4 and 5: M,M,I
  - 6: M,F,I
  - 7: M,M,F
  - 8: M,I,B
  - 9: M,B,B
  - 11: B,B,B
  - 12: M,M,B
  - 14: M,F,B
- R3: Template bit 0 puts a stop after slot 2. Template bits 4:1 equal to 1 put a stop after slot 1. Template bits 4:1 equal to 5 put a stop after slot 0. No other stops exist.
- R4: Slots leave in order. Lane 0 comes before lane 1 of the same input beat, bundles keep their acceptance order, and slots run 0,1,2 within a bundle. No slot is lost or repeated.
- R5: Output lanes valid in a cycle form a contiguous run from lane 0. The run ends at the first buffered stop, and that lane alone carries the stop flag. If no stop exists, the run is six slots with no stop flag.
- R6: Slots with no stop among them are held while fewer than six are buffered. A group then continues across bundle boundaries until a stop arrives.
- R7: in_ready is high exactly when flush is low and at most DEPTH-6 slots (6 by default) were buffered at the last clock edge. Valid lanes are taken only when in_ready is high.
- R8: Templates 6, 7, 20, 21, 26, 27, 30 and 31 are reserved. An accepted bundle with such a template adds no slots. out_illegal is high for the cycle following its acceptance edge, and the other lane's legal bundle is still taken.
- R9: A flush empties the slot buffer and clears the outputs at the next edge. In the flush cycle in_ready is low and inputs are ignored.
- R10: After reset no lane is valid, out_illegal is low and in_ready is high.
- R11: A bundle accepted at edge k can appear on the outputs after edge k+1 at the earliest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of buffered slots and outputs |
| in_valid | input | 2 | Per-lane bundle valid, lane 0 older |
| in_bundle | input | 256 | Lane 0 bundle in bits 127:0, lane 1 in bits 255:128 |
| in_ready | output | 1 | Both lanes can be accepted this cycle |
| out_valid | output | 6 | Per-lane valid of the current issue group |
| out_insn | output | 246 | 41-bit instruction per lane, lane i at bits 41*i+40:41*i |
| out_unit | output | 18 | 3-bit unit code per lane |
| out_stop | output | 6 | Stop flag per lane |
| out_illegal | output | 1 | Reserved template was dropped at the last edge |

## Verification
The bench sweeps every one of the 32 templates on lane 0 alone, on lane 1 alone, and in all 1024 two-lane pairings. The last sweep drives the buffer into back-pressure, so an off-by-one in the ready threshold would show up as lost or repeated slots.

Targeted cases check a group that straddles two bundles: a design that closed groups at bundle edges would emit three lanes, not five. They also check six stop-less slots being cut without a stop flag, a reserved bundle paired with a legal one, and a flush that lands on a held partial group. A design that let stale slots survive the flush would emit more than the three new lanes.

// File: rtl/bdl_pkg.sv
package bdl_pkg;
    localparam int INSN_W   = 41;
    localparam int TMPL_W   = 5;
    localparam int SLOTS    = 3;
    localparam int BUNDLE_W = TMPL_W + SLOTS * INSN_W;
    localparam int UNIT_W   = 3;

    typedef enum logic [UNIT_W-1:0] {
        U_MEM  = 3'd0,
        U_INT  = 3'd1,
        U_FLT  = 3'd2,
        U_BR   = 3'd3,
        U_LONG = 3'd4
    } unit_e;

    typedef struct packed {
        logic [INSN_W-1:0] insn;
        unit_e             unit;
        logic              stop;
    } slot_t;
endpackage

// File: rtl/bdl_tmpl_decode.sv
module bdl_tmpl_decode
    import bdl_pkg::*;
(
    input  logic [TMPL_W-1:0] tmpl,
    output logic              legal,
    output unit_e [SLOTS-1:0] unit,
    output logic [SLOTS-1:0]  stop
);
    logic [3:0] kind;
    assign kind = tmpl[TMPL_W-1:1];

    always_comb begin
        legal   = 1'b1;
        unit[0] = U_MEM;
        unit[1] = U_INT;
        unit[2] = U_INT;
        case (kind)
            4'd0, 4'd1: begin unit[1] = U_INT;  unit[2] = U_INT;  end
            4'd2:       begin unit[1] = U_LONG; unit[2] = U_LONG; end
            4'd4, 4'd5: begin unit[1] = U_MEM;  unit[2] = U_INT;  end
            4'd6:       begin unit[1] = U_FLT;  unit[2] = U_INT;  end
            4'd7:       begin unit[1] = U_MEM;  unit[2] = U_FLT;  end
            4'd8:       begin unit[1] = U_INT;  unit[2] = U_BR;   end
            4'd9:       begin unit[1] = U_BR;   unit[2] = U_BR;   end
            4'd11:      begin unit[0] = U_BR; unit[1] = U_BR; unit[2] = U_BR; end
            4'd12:      begin unit[1] = U_MEM;  unit[2] = U_BR;   end
            4'd14:      begin unit[1] = U_FLT;  unit[2] = U_BR;   end
            default:    legal = 1'b0;
        endcase
        stop[2] = tmpl[0];
        stop[1] = (kind == 4'd1);
        stop[0] = (kind == 4'd5);
    end
endmodule

// File: rtl/bdl_split.sv
module bdl_split
    import bdl_pkg::*;
(
    input  logic [BUNDLE_W-1:0] bundle,
    output slot_t [SLOTS-1:0]   slots,
    output logic                legal
);
    unit_e [SLOTS-1:0] units;
    logic [SLOTS-1:0]  stops;

    bdl_tmpl_decode u_dec (
        .tmpl  (bundle[TMPL_W-1:0]),
        .legal (legal),
        .unit  (units),
        .stop  (stops)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign slots[s].insn = bundle[TMPL_W + s*INSN_W +: INSN_W];
        assign slots[s].unit = units[s];
        assign slots[s].stop = stops[s];
    end
endmodule

// File: rtl/bdl_group_sel.sv
module bdl_group_sel
    import bdl_pkg::*;
#(
    parameter int ISSUE = 6,
    parameter int CNT_W = 4
) (
    input  slot_t [ISSUE-1:0] head,
    input  logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  take
);
    always_comb begin
        logic found;
        found = 1'b0;
        take  = '0;
        for (int i = 0; i < ISSUE; i++) begin
            if (!found && (i < int'(count)) && head[i].stop) begin
                found = 1'b1;
                take  = CNT_W'(i + 1);
            end
        end
        if (!found && (int'(count) >= ISSUE)) begin
            take = CNT_W'(ISSUE);
        end
    end
endmodule

// File: rtl/bundle_dispatch.sv
module bundle_dispatch
    import bdl_pkg::*;
#(
    parameter int LANES = 2,
    parameter int DEPTH = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic [LANES-1:0]            in_valid,
    input  logic [LANES*BUNDLE_W-1:0]   in_bundle,
    output logic                        in_ready,
    output logic [LANES*SLOTS-1:0]      out_valid,
    output logic [LANES*SLOTS*INSN_W-1:0] out_insn,
    output logic [LANES*SLOTS*UNIT_W-1:0] out_unit,
    output logic [LANES*SLOTS-1:0]      out_stop,
    output logic                        out_illegal
);
    localparam int ISSUE = LANES * SLOTS;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        slot_t [DEPTH-1:0] fifo;
        logic [CNT_W-1:0]  count;
        logic [ISSUE-1:0]  ov;
        slot_t [ISSUE-1:0] os;
        logic              ill;
    } state_t;

    state_t s_d, s_q;

    slot_t [SLOTS-1:0] lane_slots [LANES];
    logic [LANES-1:0]  lane_legal;
    logic [CNT_W-1:0]  take;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        bdl_split u_split (
            .bundle (in_bundle[l*BUNDLE_W +: BUNDLE_W]),
            .slots  (lane_slots[l]),
            .legal  (lane_legal[l])
        );
    end

    bdl_group_sel #(.ISSUE(ISSUE), .CNT_W(CNT_W)) u_sel (
        .head  (s_q.fifo[ISSUE-1:0]),
        .count (s_q.count),
        .take  (take)
    );

    assign in_ready = !flush && (int'(s_q.count) <= DEPTH - ISSUE);

    always_comb begin
        int rem;
        int pcnt;
        int src;
        s_d  = s_q;
        rem  = int'(s_q.count) - int'(take);
        pcnt = 0;
        for (int j = 0; j < DEPTH; j++) begin
            src = j + int'(take);
            s_d.fifo[j] = (src < int'(s_q.count)) ? s_q.fifo[IDX_W'(src)] : '0;
        end
        for (int i = 0; i < ISSUE; i++) begin
            s_d.ov[i] = (i < int'(take));
            s_d.os[i] = (i < int'(take)) ? s_q.fifo[i] : '0;
        end
        s_d.ill = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            if (in_ready && in_valid[l]) begin
                if (lane_legal[l]) begin
                    for (int s = 0; s < SLOTS; s++) begin
                        if (rem + pcnt < DEPTH) begin
                            s_d.fifo[IDX_W'(rem + pcnt)] = lane_slots[l][s];
                        end
                        pcnt = pcnt + 1;
                    end
                end else begin
                    s_d.ill = 1'b1;
                end
            end
        end
        s_d.count = CNT_W'(rem + pcnt);
        if (flush) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar i = 0; i < ISSUE; i++) begin : g_out
        assign out_insn[i*INSN_W +: INSN_W] = s_q.os[i].insn;
        assign out_unit[i*UNIT_W +: UNIT_W] = s_q.os[i].unit;
        assign out_stop[i]                  = s_q.os[i].stop;
    end
    assign out_valid   = s_q.ov;
    assign out_illegal = s_q.ill;
endmodule

// File: rtl/bundle_dispatch_chk.sv
module bundle_dispatch_chk #(
    parameter int ISSUE = 6,
    parameter int DEPTH = 12,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             in_ready,
    input logic [ISSUE-1:0] out_valid,
    input logic [ISSUE-1:0] out_stop,
    input logic             out_illegal,
    input logic [CNT_W-1:0] count
);
    // R5: valid lanes run contiguously from lane 0
    assert_valid_contig_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid & (out_valid + 1'b1)) == '0);

    // R5: at most one stop, on a valid lane that has no valid lane above it
    assert_stop_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_stop) && ((out_stop & ~out_valid) == '0)
        && (((out_stop << 1) & out_valid) == '0));

    // R7: buffered slot count never exceeds the buffer depth
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

    // R9: flush refuses input and leaves an empty block behind
    assert_flush_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !in_ready);

    assert_flush_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (out_valid == '0) && !out_illegal && (count == '0));
endmodule

bind bundle_dispatch bundle_dispatch_chk #(
    .ISSUE(ISSUE), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_stop    (out_stop),
    .out_illegal (out_illegal),
    .count       (s_q.count)
);

// File: tb/test_bundle_dispatch.sv
`timescale 1ns/1ps
module test_bundle_dispatch;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flush = 1'b0;
    logic [1:0]   in_valid = '0;
    logic [255:0] in_bundle = '0;
    logic         in_ready;
    logic [5:0]   out_valid;
    logic [245:0] out_insn;
    logic [17:0]  out_unit;
    logic [5:0]   out_stop;
    logic         out_illegal;

    int total = 0;
    int bad = 0;
    int gseq = 1;

    logic [40:0] mq_i[$];
    logic [2:0]  mq_u[$];
    logic        mq_s[$];
    logic        exp_v [6];
    logic [40:0] exp_i [6];
    logic [2:0]  exp_u [6];
    logic        exp_s [6];
    logic        exp_ill;

    always #4 clk = ~clk;

    bundle_dispatch i_bundle_dispatch (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_bundle(in_bundle), .in_ready(in_ready), .out_valid(out_valid),
        .out_insn(out_insn), .out_unit(out_unit), .out_stop(out_stop),
        .out_illegal(out_illegal)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // {legal, unit slot2, unit slot1, unit slot0}
    function automatic logic [9:0] tdec(input logic [4:0] t);
        case (t[4:1])
            4'd0, 4'd1: return {1'b1, 3'd1, 3'd1, 3'd0};
            4'd2:       return {1'b1, 3'd4, 3'd4, 3'd0};
            4'd4, 4'd5: return {1'b1, 3'd1, 3'd0, 3'd0};
            4'd6:       return {1'b1, 3'd1, 3'd2, 3'd0};
            4'd7:       return {1'b1, 3'd2, 3'd0, 3'd0};
            4'd8:       return {1'b1, 3'd3, 3'd1, 3'd0};
            4'd9:       return {1'b1, 3'd3, 3'd3, 3'd0};
            4'd11:      return {1'b1, 3'd3, 3'd3, 3'd3};
            4'd12:      return {1'b1, 3'd3, 3'd0, 3'd0};
            4'd14:      return {1'b1, 3'd3, 3'd2, 3'd0};
            default:    return 10'd0;
        endcase
    endfunction

    function automatic logic tstop(input logic [4:0] t, input int s);
        if (s == 2) return t[0];
        if (s == 1) return t[4:1] == 4'd1;
        return t[4:1] == 4'd5;
    endfunction

    task automatic mk(input logic [4:0] t, output logic [127:0] b);
        logic [31:0] h;
        b = '0;
        b[4:0] = t;
        for (int s = 0; s < 3; s++) begin
            h = 32'(gseq) * 32'h9E3779B1;
            b[5 + 41*s +: 41] = {gseq[8:0], h};
            gseq++;
        end
    endtask

    task automatic step(input logic [1:0] v, input logic [127:0] b0, input logic [127:0] b1,
                        input logic fl, output bit acc);
        logic exp_rdy;
        logic [127:0] b;
        logic [9:0] d;
        int n;
        int tk;
        bit found;
        @(negedge clk);
        in_valid = v;
        in_bundle = {b1, b0};
        flush = fl;
        #1;
        exp_rdy = !fl && (mq_i.size() <= 6);
        chk(in_ready === exp_rdy, fl ? "R9 ready during flush" : "R7 ready", 64'(in_ready), 64'(exp_rdy));
        acc = exp_rdy && (v != 2'b00);
        exp_ill = 1'b0;
        for (int i = 0; i < 6; i++) exp_v[i] = 1'b0;
        if (fl) begin
            mq_i.delete(); mq_u.delete(); mq_s.delete();
        end else begin
            n = mq_i.size();
            tk = 0;
            found = 1'b0;
            for (int i = 0; i < 6; i++) begin
                if (!found && i < n && mq_s[i]) begin
                    found = 1'b1;
                    tk = i + 1;
                end
            end
            if (!found && n >= 6) tk = 6;
            for (int i = 0; i < tk; i++) begin
                exp_v[i] = 1'b1;
                exp_i[i] = mq_i.pop_front();
                exp_u[i] = mq_u.pop_front();
                exp_s[i] = mq_s.pop_front();
            end
            if (exp_rdy) begin
                for (int l = 0; l < 2; l++) begin
                    if (v[l]) begin
                        b = (l == 0) ? b0 : b1;
                        d = tdec(b[4:0]);
                        if (d[9]) begin
                            for (int s = 0; s < 3; s++) begin
                                mq_i.push_back(b[5 + 41*s +: 41]);
                                mq_u.push_back(d[3*s +: 3]);
                                mq_s.push_back(tstop(b[4:0], s));
                            end
                        end else begin
                            exp_ill = 1'b1;
                        end
                    end
                end
            end
        end
        @(posedge clk);
        #2;
        for (int i = 0; i < 6; i++) begin
            chk(out_valid[i] === exp_v[i], "R5 R11 lane valid", 64'(out_valid[i]), 64'(exp_v[i]));
            if (exp_v[i]) begin
                chk(out_insn[41*i +: 41] === exp_i[i], "R1 R4 slot payload", 64'(out_insn[41*i +: 41]), 64'(exp_i[i]));
                chk(out_unit[3*i +: 3] === exp_u[i], "R2 unit", 64'(out_unit[3*i +: 3]), 64'(exp_u[i]));
                chk(out_stop[i] === exp_s[i], "R3 stop", 64'(out_stop[i]), 64'(exp_s[i]));
            end
        end
        chk(out_illegal === exp_ill, "R8 illegal flag", 64'(out_illegal), 64'(exp_ill));
    endtask

    task automatic send(input logic [1:0] v, input logic [4:0] t0, input logic [4:0] t1);
        logic [127:0] b0, b1;
        bit acc;
        mk(t0, b0);
        mk(t1, b1);
        do step(v, b0, b1, 1'b0, acc); while (!acc);
    endtask

    task automatic idle(input int n);
        bit acc;
        for (int i = 0; i < n; i++) step(2'b00, '0, '0, 1'b0, acc);
    endtask

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit acc;
        logic [127:0] bx;
        repeat (3) @(posedge clk);
        #2;
        chk(out_valid === 6'h00, "R10 reset valid", 64'(out_valid), 64'h0);
        chk(out_illegal === 1'b0, "R10 reset illegal", 64'(out_illegal), 64'h0);
        chk(in_ready === 1'b1, "R10 reset ready", 64'(in_ready), 64'h1);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: group straddling two bundles (3 + 2 slots)
        send(2'b01, 5'd0, 5'd0);
        send(2'b01, 5'd3, 5'd0);
        idle(1);
        chk(out_valid === 6'h1f, "R6 straddling group valid", 64'(out_valid), 64'h1f);
        chk(out_stop === 6'h10, "R6 straddling group stop", 64'(out_stop), 64'h10);
        idle(3);

        // R6: six stop-less slots are cut without a stop
        send(2'b01, 5'd0, 5'd0);
        send(2'b01, 5'd0, 5'd0);
        idle(1);
        chk(out_valid === 6'h3f, "R6 six-slot cut valid", 64'(out_valid), 64'h3f);
        chk(out_stop === 6'h00, "R6 six-slot cut stop", 64'(out_stop), 64'h0);
        idle(2);

        // R9: flush drops a held partial group and ignores its own input
        send(2'b01, 5'd0, 5'd0);
        mk(5'd1, bx);
        step(2'b01, bx, '0, 1'b1, acc);
        chk(out_valid === 6'h00, "R9 flush output", 64'(out_valid), 64'h0);
        send(2'b01, 5'd1, 5'd0);
        idle(1);
        chk(out_valid === 6'h07, "R9 only new slots after flush", 64'(out_valid), 64'h07);
        idle(2);

        // R8: reserved lane 0, legal lane 1
        send(2'b11, 5'd6, 5'd1);
        chk(out_illegal === 1'b1, "R8 illegal pulse", 64'(out_illegal), 64'h1);
        idle(1);
        chk(out_valid === 6'h07, "R8 legal lane kept", 64'(out_valid), 64'h07);
        chk(out_illegal === 1'b0, "R8 pulse ends", 64'(out_illegal), 64'h0);
        idle(2);

        // sweeps over every template
        for (int t = 0; t < 32; t++) send(2'b01, 5'(t), 5'd0);
        idle(6);
        for (int t = 0; t < 32; t++) send(2'b10, 5'd0, 5'(t));
        idle(6);
        for (int a = 0; a < 32; a++) begin
            for (int c = 0; c < 32; c++) send(2'b11, 5'(a), 5'(c));
        end
        idle(8);

        in_valid = '0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule